// File: doc/BRIEF.md
# Interrupt group register bank

One group of interrupt bookkeeping registers: a status, a mask, an identity and an enable register, each one bit per event line. Single-cycle event pulses arrive on a parallel vector; each pulse whose mask bit is clear is captured into the identity register, where it stays until software clears it by writing a one to that bit. Software reaches the four registers through a plain synchronous port with a word address, a write strobe and registered read data.

The block drives a pending vector to an upstream aggregator. A bit is pending when it is set in the identity register and also set in the enable register. The mask decides what gets captured. The enable decides what gets reported. A captured but disabled bit stays latched, and it shows up upstream as soon as it is enabled. The status register shows the raw event vector from the previous cycle, whatever the mask holds.

Top module: `intr_group_bank`

## Requirements
- R1: After reset the mask register reads all ones, and the status, identity and enable registers and the pending vector are zero.
- R2: An event pulse sets its identity bit on the next clock edge only when the matching mask bit is 0. The mask value used is the one held before any mask write in the same cycle.
- R3: A masked event is dropped. Clearing the mask afterwards does not set the identity bit.
- R4: A write to the identity register (word address 2) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R5: When an unmasked event and a write-one-to-clear hit the same identity bit in the same cycle, the bit ends up set.
- R6: The pending vector equals identity AND enable. It follows the registers combinationally, with no added cycle.
- R7: A write to the mask register (word address 1) replaces its whole value.
- R8: A write to the enable register (word address 3) replaces its whole value, and the pending vector reflects the new value right after that edge.
- R9: The status register (word address 0) holds the event vector sampled on the previous edge, whatever the mask holds. Writes to it have no effect.
- R10: The read data presented after a clock edge is the value of the register addressed before that edge: one cycle of latency. Word addresses 4 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | W | Single-cycle event pulses, one per bit |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | AW | Word address: 0 status, 1 mask, 2 identity, 3 enable |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Registered read data |
| pend_o | output | W | Identity AND enable, to the upstream aggregator |

## Verification
The bench builds the bank with W=8 and AW=4. At that width it can walk all 256 mask values and all 256 enable values, and check capture and pending against arithmetic expectations. Word addresses 4 to 15 fall in the unmapped range, which lets the bench confirm that reads there return zero and writes there are dropped. Further directed sequences cover the dropped-event case, the collision between an event and a clear, and the one-cycle read latency.

// File: rtl/intr_group_bank.sv
module intr_group_bank #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  pend_o
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_IDEN = AW'(2);
  localparam logic [AW-1:0] A_ENAB = AW'(3);

  logic [W-1:0] stat_q, mask_q, iden_q, enab_q, rd_mux;

  wire          wr_mask = wr_en_i && (addr_i == A_MASK);
  wire          wr_iden = wr_en_i && (addr_i == A_IDEN);
  wire          wr_enab = wr_en_i && (addr_i == A_ENAB);
  wire [W-1:0]  clr     = wr_iden ? wdata_i : '0;
  wire [W-1:0]  cap     = evt_i & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
      iden_q <= '0;
      enab_q <= '0;
    end else begin
      stat_q <= evt_i;
      iden_q <= (iden_q & ~clr) | cap;
      if (wr_mask) mask_q <= wdata_i;
      if (wr_enab) enab_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rd_mux = stat_q;
      A_MASK:  rd_mux = mask_q;
      A_IDEN:  rd_mux = iden_q;
      A_ENAB:  rd_mux = enab_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_mux;
  end

  assign pend_o = iden_q & enab_q;
endmodule

module intr_group_bank_chk #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  evt_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_o,
  input logic [W-1:0]  pend_o,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  iden_q,
  input logic [W-1:0]  enab_q
);
  assert_masked_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((iden_q & $past(evt_i & mask_q & ~iden_q)) == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ~mask_q) != '0) |=> ((iden_q & $past(evt_i & ~mask_q)) == $past(evt_i & ~mask_q)));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(2)) |=> ((iden_q & $past(wdata_i & ~(evt_i & ~mask_q))) == '0));

  assert_mask_replace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(1)) |=> (mask_q == $past(wdata_i)));

  assert_enab_replace_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(3)) |=> (enab_q == $past(wdata_i)));

  assert_pend_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q == '0) |-> (pend_o == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i > AW'(3)) |=> (rdata_o == '0));
endmodule

bind intr_group_bank intr_group_bank_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_o(pend_o),
  .mask_q(mask_q), .iden_q(iden_q), .enab_q(enab_q)
);

// File: tb/intr_group_bank_tb.sv
module intr_group_bank_tb;
  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  evt = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata, pend;
  int checks = 0;
  int failures = 0;
  logic [W-1:0]  got;

  always #10 clk = ~clk;

  intr_group_bank #(.W(W), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pend_o(pend)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [W-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(0, got); chk("R1 status", got, 8'h00);
    rd(1, got); chk("R1 mask", got, 8'hFF);
    rd(2, got); chk("R1 identity", got, 8'h00);
    rd(3, got); chk("R1 enable", got, 8'h00);
    chk("R1 pending", pend, 8'h00);

    // R2 / R7 mask sweep
    for (int m = 0; m < 256; m++) begin
      logic [W-1:0] e;
      e = W'((m * 37 + 11) & 255);
      wr(1, W'(m));
      rd(1, got); chk("R7 mask readback", got, W'(m));
      wr(2, 8'hFF);
      pulse(e);
      rd(2, got); chk("R2 masked capture", got, e & ~W'(m));
    end

    // R3 masked event is dropped
    wr(1, 8'hFF); wr(2, 8'hFF);
    pulse(8'hAA);
    wr(1, 8'h00);
    rd(2, got); chk("R3 dropped not deferred", got, 8'h00);

    // R6 / R8 enable sweep with all identity bits set
    pulse(8'hFF);
    for (int en = 0; en < 256; en++) begin
      wr(3, W'(en));
      chk("R8 pending after enable write", pend, W'(en));
    end
    wr(2, 8'h0F);
    chk("R6 pending follows identity", pend, 8'hF0);
    wr(3, 8'h00);

    // R4 write-one-to-clear sweep
    for (int p = 0; p < 256; p += 7) begin
      pulse(8'hFF);
      wr(2, W'(p));
      rd(2, got); chk("R4 w1c", got, ~W'(p));
    end

    // R5 collision: event and clear on same bits
    wr(2, 8'hFF); pulse(8'h0F);
    @(negedge clk); wr_en = 1'b1; addr = 2; wdata = 8'hFF; evt = 8'h05;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rd(2, got); chk("R5 event wins", got, 8'h05);

    // R9 status shows raw events regardless of mask, writes ignored
    wr(1, 8'hFF);
    @(negedge clk); addr = 0; evt = 8'h3C;
    @(negedge clk); evt = '0;
    @(negedge clk); chk("R9 status raw", rdata, 8'h3C);
    wr(0, 8'hFF);
    rd(0, got); chk("R9 status write ignored", got, 8'h00);

    // R10 latency and unmapped addresses
    wr(1, 8'h5A);
    rd(1, got); chk("R10 read mask", got, 8'h5A);
    @(negedge clk); addr = 4'd7;
    #1 chk("R10 one-cycle latency hold", rdata, 8'h5A);
    @(negedge clk); chk("R10 unmapped read", rdata, 8'h00);
    for (int a = 4; a < 16; a++) begin
      wr(AW'(a), 8'hC3);
      rd(AW'(a), got); chk("R10 unmapped read zero", got, 8'h00);
    end
    rd(1, got); chk("R10 unmapped write no effect mask", got, 8'h5A);
    rd(3, got); chk("R10 unmapped write no effect enable", got, 8'h00);
    rd(2, got); chk("R10 unmapped write no effect identity", got, 8'h05);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule